// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines, called A, B, C and D, onto sixteen legacy interrupt-controller inputs. Software sets the steering through four byte-wide routing registers. They are reached through a simple write port that carries a byte address, a four-bit byte enable and 32-bit data. Each routing byte names the legacy input that its line drives. A value of sixteen or more takes the line out of service.

Internally the router keeps a level map with one bit for each pairing of legacy input and request line. Any write that lands on a routing byte clears this map. The map is then rebuilt from the present line levels under the new routing, so no stale pairing survives a reprogramming. Each legacy output is the OR of its four map bits and is registered. Outputs therefore follow a line change or a routing write one clock later.

A separate combinational path gives the shared line used by a device. It takes a device number and an interrupt pin (A to D) and applies a rotating swizzle.

Top module: `irq_line_router`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every routing register returns to 0x80 and `irq_out` is all zero.
- R2: A write whose `wr_addr[7:2]` equals 6'h18 (bytes 0x60 to 0x63) loads byte lane k, `wr_data[8k+7:8k]`, into the routing register of line k (A=0, B=1, C=2, D=3) for every k with `wr_be[k]` high. Lanes whose enable is low are kept, and `wr_addr[1:0]` is ignored.
- R3: A write to any other 32-bit word leaves the routing unchanged, so `irq_out` keeps its value while the line levels stay the same.
- R4: A line whose routing value is 16 or more drives no output, whatever its level. After reset all lines are in this state.
- R5: One clock after the line levels are sampled, `irq_out[j]` is high exactly when some in-service line routed to j is high.
- R6: When two lines are routed to the same output, that output stays asserted until both lines are low.
- R7: A routing write drops the old pairing of a line on the next clock, and the new pairing takes the level that the line has in the write cycle.
- R8: `dev_line` equals (dev_pin + dev_num − 1) mod 4, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write; bits [1:0] are ignored |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data, lane k in bits [8k+7:8k] |
| line_level | input | 4 | Current levels of request lines A..D (bit 0 = A) |
| dev_num | input | 5 | Device number for the swizzle |
| dev_pin | input | 2 | Interrupt pin of the device, A=0..D=3 |
| dev_line | output | 2 | Shared line that the device pin lands on |
| irq_out | output | 16 | Legacy interrupt-controller inputs |

## Verification
The assertions assume that the inputs are sampled only at the rising edge. They also assume that the line levels and the write port hold known values from the first clock onward. The bench drives every input on the falling edge and gives each one a defined value before reset is released. The swizzle property further assumes that the pin input steps by one while the device number holds. The bench sweeps the pin inner loop in exactly that way.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int NUM_LINES   = 4;
    localparam int NUM_OUTS    = 16;
    localparam int LINE_W      = $clog2(NUM_LINES);
    localparam int OUT_W       = $clog2(NUM_OUTS);
    localparam int MAP_BITS    = NUM_OUTS * NUM_LINES;
    localparam int ROUTE_W     = 8;
    localparam int ADDR_W      = 8;
    localparam int DEV_W       = 5;
    localparam int LANES       = 4;
    localparam int DATA_W      = LANES * ROUTE_W;
    localparam logic [ADDR_W-3:0] ROUTE_WORD  = 6'h18;
    localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;
    typedef route_t [NUM_LINES-1:0] route_arr_t;

    typedef struct packed {
        logic             live;
        logic [OUT_W-1:0] idx;
    } target_t;

    function automatic target_t decode_route(input route_t r);
        target_t t;
        t.live = (r < route_t'(NUM_OUTS));
        t.idx  = r[OUT_W-1:0];
        return t;
    endfunction

    function automatic logic [LINE_W-1:0] swizzle(input logic [LINE_W-1:0] pin,
                                                  input logic [DEV_W-1:0]  dev);
        logic [LINE_W-1:0] d;
        d = dev[LINE_W-1:0];
        return pin + d - LINE_W'(1);
    endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output route_arr_t        routes_nxt,
    output logic              route_wr
);
    route_arr_t routes_q;
    logic       word_hit;

    assign word_hit = wr_en && (wr_addr[ADDR_W-1:2] == ROUTE_WORD);

    always_comb begin
        routes_nxt = routes_q;
        route_wr   = 1'b0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (word_hit && wr_be[k]) begin
                routes_nxt[k] = wr_data[k*ROUTE_W +: ROUTE_W];
                route_wr      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) routes_q <= {NUM_LINES{ROUTE_RESET}};
        else     routes_q <= routes_nxt;
    end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 route_wr,
    input  route_arr_t           routes_nxt,
    input  logic [NUM_LINES-1:0] line_level,
    output logic [MAP_BITS-1:0]  map_nxt
);
    logic [MAP_BITS-1:0] map_q;
    target_t             tgt [NUM_LINES];

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) tgt[l] = decode_route(routes_nxt[l]);
    end

    always_comb begin
        // a routing change rebuilds the map from scratch; otherwise only the
        // routed bit of each live line is refreshed
        map_nxt = route_wr ? '0 : map_q;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (tgt[l].live) map_nxt[int'(tgt[l].idx) * NUM_LINES + l] = line_level[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_nxt;
    end
endmodule

// File: rtl/irq_out_merge.sv
module irq_out_merge
    import irq_route_pkg::*;
(
    input  logic [MAP_BITS-1:0] map_in,
    output logic [NUM_OUTS-1:0] out_any
);
    for (genvar j = 0; j < NUM_OUTS; j++) begin : g_out
        assign out_any[j] = |map_in[j*NUM_LINES +: NUM_LINES];
    end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [LANES-1:0]     wr_be,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_LINES-1:0] line_level,
    input  logic [DEV_W-1:0]     dev_num,
    input  logic [LINE_W-1:0]    dev_pin,
    output logic [LINE_W-1:0]    dev_line,
    output logic [NUM_OUTS-1:0]  irq_out
);
    route_arr_t          routes_nxt;
    logic                route_wr;
    logic [MAP_BITS-1:0] map_nxt;
    logic [NUM_OUTS-1:0] out_nxt;

    irq_route_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data),
        .routes_nxt(routes_nxt), .route_wr(route_wr)
    );

    irq_level_map u_map (
        .clk(clk), .rst(rst), .route_wr(route_wr), .routes_nxt(routes_nxt),
        .line_level(line_level), .map_nxt(map_nxt)
    );

    irq_out_merge u_merge (.map_in(map_nxt), .out_any(out_nxt));

    always_ff @(posedge clk) begin
        if (rst) irq_out <= '0;
        else     irq_out <= out_nxt;
    end

    assign dev_line = swizzle(dev_pin, dev_num);
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
    import irq_route_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [LANES-1:0]     wr_be,
    input logic [NUM_LINES-1:0] line_level,
    input logic [DEV_W-1:0]     dev_num,
    input logic [LINE_W-1:0]    dev_pin,
    input logic [LINE_W-1:0]    dev_line,
    input logic [NUM_OUTS-1:0]  irq_out
);
    logic route_touched;
    logic other_word;

    assign other_word = wr_en && (wr_addr[ADDR_W-1:2] != ROUTE_WORD);

    always_ff @(posedge clk) begin
        if (rst) route_touched <= 1'b0;
        else if (wr_en && (wr_addr[ADDR_W-1:2] == ROUTE_WORD) && (|wr_be)) route_touched <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_out == '0));

    a_r4_default_disabled: assert property (@(posedge clk) disable iff (rst)
        !route_touched |-> (irq_out == '0));

    a_r5_all_low: assert property (@(posedge clk) disable iff (rst)
        (line_level == '0) |=> (irq_out == '0));

    a_r5_at_most_lines: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= NUM_LINES);

    a_r3_other_word: assert property (@(posedge clk) disable iff (rst)
        (other_word && !$past(rst) && line_level == $past(line_level)) |=> $stable(irq_out));

    a_r8_pin_step: assert property (@(posedge clk) disable iff (rst)
        ($stable(dev_num) && dev_pin == LINE_W'($past(dev_pin) + 1'b1))
        |-> dev_line == LINE_W'($past(dev_line) + 1'b1));
endmodule

bind irq_line_router irq_router_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .line_level(line_level), .dev_num(dev_num), .dev_pin(dev_pin),
    .dev_line(dev_line), .irq_out(irq_out)
);

// File: tb/irq_line_router_bench.sv
module irq_line_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  line_level = '0;
    logic [4:0]  dev_num = '0;
    logic [1:0]  dev_pin = '0;
    logic [1:0]  dev_line;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_line_router u_irq_line_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .line_level(line_level), .dev_num(dev_num),
        .dev_pin(dev_pin), .dev_line(dev_line), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: routing table as integers, outputs rebuilt per edge
    int          m_route [4];
    logic [15:0] exp_q = '0;
    logic [15:0] m_tmp;
    bit          m_valid = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_route[i]) m_route[i] = 128;
            exp_q = '0;
            m_valid = 1'b1;
        end else begin
            if (wr_en && wr_addr[7:2] == 6'h18)
                for (int b = 0; b < 4; b++) if (wr_be[b]) m_route[b] = int'(wr_data[8*b +: 8]);
            m_tmp = '0;
            for (int l = 0; l < 4; l++)
                if (m_route[l] < 16 && line_level[l]) m_tmp[m_route[l]] = 1'b1;
            exp_q = m_tmp;
        end
    end

    always @(negedge clk) if (m_valid && !done) chk("R5 model", int'(irq_out), int'(exp_q));

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic lv(input logic [3:0] v);
        line_level = v;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", int'(irq_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", int'(irq_out), 0);
        lv(4'hF);
        chk("R4 default disabled", int'(irq_out), 0);

        wr(8'h60, 4'hF, 32'h0B0A_0509);          // A->9 B->5 C->10 D->11
        chk("R2 full word", int'(irq_out), 16'h0E20);

        wr(8'h60, 4'b0011, 32'h0000_0303);        // A,B -> 3
        chk("R6 shared", int'(irq_out), 16'h0C08);
        lv(4'b1110);
        chk("R6 one dropped", int'(irq_out), 16'h0C08);
        lv(4'b1100);
        chk("R6 both dropped", int'(irq_out), 16'h0C00);
        lv(4'b1101);
        chk("R6 back up", int'(irq_out), 16'h0C08);

        wr(8'h60, 4'b0100, 32'h0010_0000);        // C -> 0x10 disabled
        chk("R4 disabled line", int'(irq_out), 16'h0808);
        lv(4'b1111);
        chk("R4 disabled high", int'(irq_out), 16'h0808);

        wr(8'h64, 4'hF, 32'h0000_0000);
        chk("R3 word above", int'(irq_out), 16'h0808);
        wr(8'h5C, 4'hF, 32'h0101_0101);
        chk("R3 word below", int'(irq_out), 16'h0808);

        wr(8'h62, 4'b1000, 32'h07FF_FFFF);        // D -> 7 via unaligned address
        chk("R2 lane enable", int'(irq_out), 16'h0088);
        chk("R7 old pairing dropped", int'(irq_out[11]), 0);

        lv(4'b0000);
        chk("R5 all low", int'(irq_out), 0);
        wr(8'h60, 4'b0001, 32'h0000_000E);        // A -> 14 while low
        chk("R7 rebuild low", int'(irq_out), 0);
        lv(4'b0001);
        chk("R7 new pairing", int'(irq_out), 16'h4000);
        wr(8'h60, 4'b0001, 32'h0000_0001);        // A -> 1 while high
        chk("R7 move while high", int'(irq_out), 16'h0002);

        for (int d = 0; d < 32; d++) begin
            for (int p = 0; p < 4; p++) begin
                dev_num = 5'(d); dev_pin = 2'(p);
                @(negedge clk);
                chk("R8 swizzle", int'(dev_line), (p + d + 3) % 4);
            end
        end

        lv(4'hF);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run", int'(irq_out), 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 routes restored", int'(irq_out), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule